// File: doc/BRIEF.md
# DDR SDRAM Power-Up Mode-Register Sequencer

This block performs the mode-register bring-up of an external DDR1 or DDR2 memory without any software involvement. A single-cycle `start` pulse launches one of two fixed scripts. The script is chosen by a memory-type strap. A second strap tells the block whether the reference clock is 40 MHz or 25 MHz. Both straps are captured at the moment of launch. Each script step is one of two kinds. A command step is a one-hot pulse on the memory controller's command port, with a 16-bit mode value beside it. A register step is a write strobe to one of four controller registers: the DDR2 configuration word, the refresh word, and the two DQS delay taps.

Each step lasts one clock cycle, and successive steps start exactly `GAP` clocks apart, so the memory gets a guaranteed settling time between commands. When the DDR2 script runs, it first programs the configuration word. Both scripts end with the same three register writes: the refresh word (whose interval depends on the clock strap), then the lane 0 tap, then the lane 1 tap. `busy` stays high for the whole run. After the run, `done` stays high until the next launch.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_valid` and `wr_valid` are low, and `cmd_sel`, `wr_sel` and `step_data` are zero.
- R2: A `start` sampled while not busy raises `busy` and clears `done` in the next cycle. For a script of N steps, `busy` stays high for exactly N*GAP+1 cycles. When `busy` falls, `done` rises and stays high until the next accepted `start`.
- R3: A `start` sampled while `busy` is high is ignored. It changes neither the run length nor the step sequence.
- R4: `cmd_sel` is one-hot while `cmd_valid` is high and zero otherwise. The bit positions are: 0 = mode register, 1 = extended mode register, 2 = auto-refresh, 3 = precharge-all, 4 = EMR2, 5 = EMR3.
- R5: With the DDR2 strap high, the command steps and their `step_data` values are, in order: precharge-all (0), EMR2 0x0000, EMR3 0x0000, EMR 0x0000, MR 0x0100, precharge-all (0), auto-refresh (0), auto-refresh (0), MR 0x0A33, EMR 0x0382, EMR 0x0402.
- R6: With the DDR2 strap low, the command steps are, in order: precharge-all (0), MR 0x0133, EMR 0x0002, precharge-all (0), MR 0x0033.
- R7: In DDR2 mode only, the first step writes `wr_sel`=0 with the configuration word 0x0A59. In that word, bits 13:10 hold write latency 2, bit 9 enables ODT, bits 7:2 hold tFAW 22, and bit 0 is the enable bit.
- R8: After the last command step, a write with `wr_sel`=1 carries bit 14 set plus a 10-bit interval in bits 9:0. The interval is 624 (0x4270) when the 40 MHz strap is set and 390 (0x4186) otherwise.
- R9: After the refresh write come a write with `wr_sel`=2 and data 0x0008, then a write with `wr_sel`=3 and data 0x0009.
- R10: Every step is a single-cycle pulse on exactly one of `cmd_valid` and `wr_valid`. The first step appears two cycles after the `start` cycle, and each later step appears exactly GAP cycles after the previous one.
- R11: The straps are sampled only when `start` is accepted. Changing them during a run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| strap_ddr2 | input | 1 | Memory type strap: 1 = DDR2, 0 = DDR1 |
| strap_ref40 | input | 1 | Reference clock strap: 1 = 40 MHz, 0 = 25 MHz |
| cmd_valid | output | 1 | Command pulse |
| cmd_sel | output | 6 | One-hot command select |
| wr_valid | output | 1 | Register write pulse |
| wr_sel | output | 2 | Register select: 0 config, 1 refresh, 2 tap lane 0, 3 tap lane 1 |
| step_data | output | 16 | Mode value or register data of the current step |
| busy | output | 1 | Script running |
| done | output | 1 | Script complete, held until next start |

## Verification
The assertions check the following on every cycle:
- The command select is one-hot.
- The two strobes are mutually exclusive, each lasts one cycle, and each occurs only while `busy` is high.
- The spacing between consecutive pulses equals GAP.
- `busy` and `done` hold their values, and a start during a run cannot disturb `busy`.

The assertions cannot show whether the right commands come in the right order with the right mode words. Nor can they show that the refresh interval follows the clock strap or that the straps are captured only at launch. Those properties show only in the bench's scenarios: each strap combination, a spurious start in the middle of a run, and a strap change in the middle of a run, all compared cycle by cycle against the reference model.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int CMD_W  = 6;
  localparam int DATA_W = 16;
  localparam int WSEL_W = 2;

  // command-port bit positions
  localparam int CB_MR   = 0;
  localparam int CB_EMR  = 1;
  localparam int CB_AREF = 2;
  localparam int CB_PREA = 3;
  localparam int CB_EMR2 = 4;
  localparam int CB_EMR3 = 5;

  // register-write targets
  localparam int WS_CFG  = 0;
  localparam int WS_REF  = 1;
  localparam int WS_TAP0 = 2;
  localparam int WS_TAP1 = 3;

  localparam int DDR2_STEPS = 15;
  localparam int DDR1_STEPS = 8;
  localparam int IDX_W      = $clog2(DDR2_STEPS + 1);

  typedef enum logic [1:0] {
    STEP_CMD = 2'd0,
    STEP_WR  = 2'd1,
    STEP_END = 2'd2
  } step_kind_e;

  typedef struct packed {
    step_kind_e          kind;
    logic [CMD_W-1:0]    cmd;
    logic [WSEL_W-1:0]   wsel;
    logic [DATA_W-1:0]   data;
  } step_t;

  function automatic step_t mk_cmd(int bitpos, logic [DATA_W-1:0] d);
    step_t s;
    s.kind = STEP_CMD;
    s.cmd  = CMD_W'(1) << bitpos;
    s.wsel = '0;
    s.data = d;
    return s;
  endfunction

  function automatic step_t mk_wr(int sel, logic [DATA_W-1:0] d);
    step_t s;
    s.kind = STEP_WR;
    s.cmd  = '0;
    s.wsel = WSEL_W'(sel);
    s.data = d;
    return s;
  endfunction

  function automatic step_t mk_end();
    step_t s;
    s.kind = STEP_END;
    s.cmd  = '0;
    s.wsel = '0;
    s.data = '0;
    return s;
  endfunction

  // enable bit 14 plus a 10-bit interval chosen by the clock strap
  function automatic logic [DATA_W-1:0] refresh_word(logic ref40, int int40, int int25);
    int iv;
    iv = ref40 ? int40 : int25;
    return DATA_W'((1 << 14) | (iv & 'h3ff));
  endfunction

  // write latency [13:10], ODT [9], tFAW [7:2], enable [0]
  function automatic logic [DATA_W-1:0] ddr2_cfg_word(int twl, int tfaw);
    return DATA_W'(((twl & 'hf) << 10) | (1 << 9) | ((tfaw & 'h3f) << 2) | 1);
  endfunction

endpackage

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = (GAP > 2) ? $clog2(GAP) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(GAP - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_init_script.sv
module ddr_init_script
  import ddr_init_pkg::*;
#(
  parameter int REF_INT_40 = 624,
  parameter int REF_INT_25 = 390,
  parameter int TAP_LANE0  = 8,
  parameter int TAP_LANE1  = 9,
  parameter int DDR2_TWL   = 2,
  parameter int DDR2_TFAW  = 22
) (
  input  logic             ddr2,
  input  logic             ref40,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  logic [DATA_W-1:0] ref_word;
  logic [DATA_W-1:0] cfg_word;
  step_t             s_ddr2;
  step_t             s_ddr1;

  assign ref_word = refresh_word(ref40, REF_INT_40, REF_INT_25);
  assign cfg_word = ddr2_cfg_word(DDR2_TWL, DDR2_TFAW);

  always_comb begin
    case (idx)
      4'd0:    s_ddr2 = mk_wr(WS_CFG, cfg_word);
      4'd1:    s_ddr2 = mk_cmd(CB_PREA, 16'h0000);
      4'd2:    s_ddr2 = mk_cmd(CB_EMR2, 16'h0000);
      4'd3:    s_ddr2 = mk_cmd(CB_EMR3, 16'h0000);
      4'd4:    s_ddr2 = mk_cmd(CB_EMR,  16'h0000);
      4'd5:    s_ddr2 = mk_cmd(CB_MR,   16'h0100);
      4'd6:    s_ddr2 = mk_cmd(CB_PREA, 16'h0000);
      4'd7:    s_ddr2 = mk_cmd(CB_AREF, 16'h0000);
      4'd8:    s_ddr2 = mk_cmd(CB_AREF, 16'h0000);
      4'd9:    s_ddr2 = mk_cmd(CB_MR,   16'h0A33);
      4'd10:   s_ddr2 = mk_cmd(CB_EMR,  16'h0382);
      4'd11:   s_ddr2 = mk_cmd(CB_EMR,  16'h0402);
      4'd12:   s_ddr2 = mk_wr(WS_REF,  ref_word);
      4'd13:   s_ddr2 = mk_wr(WS_TAP0, DATA_W'(TAP_LANE0));
      4'd14:   s_ddr2 = mk_wr(WS_TAP1, DATA_W'(TAP_LANE1));
      default: s_ddr2 = mk_end();
    endcase
  end

  always_comb begin
    case (idx)
      4'd0:    s_ddr1 = mk_cmd(CB_PREA, 16'h0000);
      4'd1:    s_ddr1 = mk_cmd(CB_MR,   16'h0133);
      4'd2:    s_ddr1 = mk_cmd(CB_EMR,  16'h0002);
      4'd3:    s_ddr1 = mk_cmd(CB_PREA, 16'h0000);
      4'd4:    s_ddr1 = mk_cmd(CB_MR,   16'h0033);
      4'd5:    s_ddr1 = mk_wr(WS_REF,  ref_word);
      4'd6:    s_ddr1 = mk_wr(WS_TAP0, DATA_W'(TAP_LANE0));
      4'd7:    s_ddr1 = mk_wr(WS_TAP1, DATA_W'(TAP_LANE1));
      default: s_ddr1 = mk_end();
    endcase
  end

  assign step = ddr2 ? s_ddr2 : s_ddr1;
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int GAP        = 16,
  parameter int REF_INT_40 = 624,
  parameter int REF_INT_25 = 390,
  parameter int TAP_LANE0  = 8,
  parameter int TAP_LANE1  = 9,
  parameter int DDR2_TWL   = 2,
  parameter int DDR2_TFAW  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              strap_ddr2,
  input  logic              strap_ref40,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_sel,
  output logic              wr_valid,
  output logic [WSEL_W-1:0] wr_sel,
  output logic [DATA_W-1:0] step_data,
  output logic              busy,
  output logic              done
);
  logic             run_ddr2;
  logic             run_ref40;
  logic [IDX_W-1:0] idx;
  step_t            cur_step;
  logic             gap_expired;

  // named internal events
  logic launch;
  logic issue;
  logic finish;

  assign launch = start && !busy;
  assign issue  = busy && gap_expired && (cur_step.kind != STEP_END);
  assign finish = busy && gap_expired && (cur_step.kind == STEP_END);

  ddr_init_script #(
    .REF_INT_40 (REF_INT_40),
    .REF_INT_25 (REF_INT_25),
    .TAP_LANE0  (TAP_LANE0),
    .TAP_LANE1  (TAP_LANE1),
    .DDR2_TWL   (DDR2_TWL),
    .DDR2_TFAW  (DDR2_TFAW)
  ) u_script (
    .ddr2  (run_ddr2),
    .ref40 (run_ref40),
    .idx   (idx),
    .step  (cur_step)
  );

  ddr_init_gap_timer #(.GAP(GAP)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (launch),
    .load    (issue),
    .expired (gap_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      idx       <= '0;
      run_ddr2  <= 1'b0;
      run_ref40 <= 1'b0;
    end else if (launch) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      idx       <= '0;
      run_ddr2  <= strap_ddr2;
      run_ref40 <= strap_ref40;
    end else if (finish) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (issue) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_sel   <= '0;
      wr_valid  <= 1'b0;
      wr_sel    <= '0;
      step_data <= '0;
    end else begin
      cmd_valid <= issue && (cur_step.kind == STEP_CMD);
      cmd_sel   <= (issue && cur_step.kind == STEP_CMD) ? cur_step.cmd : '0;
      wr_valid  <= issue && (cur_step.kind == STEP_WR);
      wr_sel    <= (issue && cur_step.kind == STEP_WR) ? cur_step.wsel : '0;
      step_data <= issue ? cur_step.data : '0;
    end
  end
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
#(
  parameter int GAP = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              launch,
  input logic              issue,
  input logic              finish,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_sel,
  input logic              wr_valid,
  input logic [WSEL_W-1:0] wr_sel,
  input logic [DATA_W-1:0] step_data,
  input logic              busy,
  input logic              done
);
  logic        pulse;
  logic        seen;
  logic [15:0] since;

  assign pulse = cmd_valid || wr_valid;

  // cycles since the previous pulse within the current run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      since <= '0;
    end else if (launch) begin
      seen  <= 1'b0;
      since <= '0;
    end else if (pulse) begin
      seen  <= 1'b1;
      since <= '0;
    end else if (since != 16'hffff) begin
      since <= since + 1'b1;
    end
  end

  assert_cmd_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(cmd_sel) == 1);

  assert_cmd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_sel == '0);

  assert_wr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (wr_sel == '0 && (cmd_valid || step_data == '0)));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wr_valid));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_issue_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> pulse);

  assert_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && seen) |-> since == 16'(GAP - 1));

  assert_pulse_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> busy);

  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);

  assert_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.GAP(GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .launch    (launch),
  .issue     (issue),
  .finish    (finish),
  .cmd_valid (cmd_valid),
  .cmd_sel   (cmd_sel),
  .wr_valid  (wr_valid),
  .wr_sel    (wr_sel),
  .step_data (step_data),
  .busy      (busy),
  .done      (done)
);

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        s_ddr2 = 1'b0;
  logic        s_ref40 = 1'b0;
  logic        cmd_valid;
  logic [5:0]  cmd_sel;
  logic        wr_valid;
  logic [1:0]  wr_sel;
  logic [15:0] step_data;
  logic        busy;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int q_kind[$];   // 0 command, 1 register write
  int q_sel[$];
  int q_data[$];
  int m = 0;
  bit m_busy = 0;
  bit m_done = 0;
  bit m_ddr2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(.GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strap_ddr2(s_ddr2), .strap_ref40(s_ref40),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .wr_valid(wr_valid), .wr_sel(wr_sel),
    .step_data(step_data), .busy(busy), .done(done)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int k, int s, int d);
    q_kind.push_back(k);
    q_sel.push_back(s);
    q_data.push_back(d);
  endtask

  task automatic build(bit ddr2, bit ref40);
    int refw;
    q_kind.delete(); q_sel.delete(); q_data.delete();
    refw = 16384 + (ref40 ? 624 : 390);
    if (ddr2) begin
      push(1, 0, 2*1024 + 512 + 22*4 + 1);
      push(0, 3, 0); push(0, 4, 0); push(0, 5, 0); push(0, 1, 0);
      push(0, 0, 'h100); push(0, 3, 0); push(0, 2, 0); push(0, 2, 0);
      push(0, 0, 'hA33); push(0, 1, 'h382); push(0, 1, 'h402);
    end else begin
      push(0, 3, 0); push(0, 0, 'h133); push(0, 1, 'h2);
      push(0, 3, 0); push(0, 0, 'h33);
    end
    push(1, 1, refw); push(1, 2, 8); push(1, 3, 9);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m = 0;
    end else if (!m_busy && start) begin
      build(s_ddr2, s_ref40);
      m = 0; m_busy = 1; m_done = 0; m_ddr2 = s_ddr2;
    end else if (m_busy) begin
      m++;
      if (m > q_kind.size() * GAP) begin
        m_busy = 0; m_done = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int k;
    int e_cv, e_cs, e_wv, e_ws, e_d;
    string dtag;
    k = -1;
    if ((m_busy || m_done) && m >= 1 && (m - 1) % GAP == 0 && (m - 1) / GAP < q_kind.size())
      k = (m - 1) / GAP;
    e_cv = (k >= 0 && q_kind[k] == 0) ? 1 : 0;
    e_wv = (k >= 0 && q_kind[k] == 1) ? 1 : 0;
    e_cs = e_cv ? (1 << q_sel[k]) : 0;
    e_ws = e_wv ? q_sel[k] : 0;
    e_d  = (k >= 0) ? q_data[k] : 0;
    dtag = m_ddr2 ? "R5" : "R6";
    if (e_wv) dtag = (q_sel[k] == 0) ? "R7" : (q_sel[k] == 1) ? "R8" : "R9";
    check("R10", "cmd_valid", int'(cmd_valid), e_cv);
    check("R10", "wr_valid", int'(wr_valid), e_wv);
    check("R4", "cmd_sel", int'(cmd_sel), e_cs);
    check(dtag, "wr_sel", int'(wr_sel), e_ws);
    check(dtag, "step_data", int'(step_data), e_d);
    check("R2", "busy", int'(busy), int'(m_busy));
    check("R2", "done", int'(done), int'(m_done));
  end

  task automatic run(bit ddr2, bit ref40, bit mid_start, bit mid_strap, string tag);
    int cnt;
    int n;
    n = ddr2 ? 15 : 8;
    @(negedge clk);
    s_ddr2 = ddr2; s_ref40 = ref40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy && cnt < 100000) begin
      cnt++;
      if (mid_start && cnt == 40) start = 1'b1;
      if (mid_start && cnt == 41) start = 1'b0;
      if (mid_strap && cnt == 50) begin
        s_ddr2 = ~s_ddr2; s_ref40 = ~s_ref40;
      end
      @(negedge clk);
    end
    check(tag, "run length", cnt, n * GAP + 1);
    check(tag, "done after run", int'(done), 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "strobes", int'(cmd_valid) + int'(wr_valid), 0);
    check("R1", "data", int'(step_data), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(1'b1, 1'b1, 1'b0, 1'b0, "R2");   // DDR2, 40 MHz
    run(1'b0, 1'b0, 1'b0, 1'b0, "R2");   // DDR1, 25 MHz
    run(1'b1, 1'b0, 1'b1, 1'b0, "R3");   // start while busy ignored
    run(1'b0, 1'b1, 1'b0, 1'b1, "R11");  // straps toggled mid-run
    run(1'b1, 1'b1, 1'b1, 1'b1, "R11");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule